// File: doc/BRIEF.md
# Memory-Set Instruction Decoder

This block examines a 32-bit instruction word and recognises the three instructions that together perform a memory fill. The prologue, main and epilogue phases share one opcode pattern and differ in a 2-bit phase field. For a recognised word the decoder pulls out three register numbers: the fill-data register, the byte-count register and the destination-address register. It also extracts two access-flavour flags, one for a non-temporal hint and one for unprivileged access.

The decoder flags register combinations that the architecture forbids as undefined. It also builds a syndrome word for a later stage. That stage uses the syndrome to report a mismatch exception and to recover the three register numbers without decoding the word again.

The decoder logic is combinational. All results are captured in one output register stage, one cycle after the input strobe. There is no backpressure. A word that is not a memory-set instruction leaves both the valid and undefined outputs low, so that a neighbouring decoder can claim it.

Top module: `memset_decoder`

## Requirements
- R1: A word is recognised when all of the following hold: bits [31:30] = 00, bits [29:21] = 011001110, bits [11:10] = 01, and bits [15:14] are not 11. When `in_valid` is high with a recognised word, `out_valid` is high in the following cycle.
- R2: If `in_valid` is low, or the word is not recognised, `out_valid` and `out_undef` are both 0 in the following cycle.
- R3: `out_phase` equals word bits [15:14]. The encodings are 00 = prologue, 01 = main and 10 = epilogue.
- R4: `out_data_reg` = bits [20:16], `out_size_reg` = bits [9:5] and `out_dest_reg` = bits [4:0].
- R5: `out_nontemp` = bit 13 and `out_unpriv` = bit 12.
- R6: For a recognised word, `out_undef` is 1 when any two of the three register numbers are equal.
- R7: For a recognised word, `out_undef` is 1 when the destination or size register number is 31. A data register number of 31 alone does not make the word undefined.
- R8: In `out_syndrome`, the destination number is at [14:10], the data number at [9:5] and the size number at [4:0].
- R9: In `out_syndrome`, the remaining fields are:
  - bit 24 (format indicator) = 1;
  - bits [20:19] = {nontemp, unpriv};
  - bit 18 = 1 exactly for the epilogue phase;
  - bit 17 (wrong-format) = 0;
  - bits [23:21] and [16:15] = 0.
- R10: After reset, every output is 0.
- R11: Phase, register numbers, flags and syndrome change only on a recognised word with `in_valid` high. In every other cycle they keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Registered: recognised memory-set word |
| out_phase | output | 2 | Phase code |
| out_data_reg | output | 5 | Fill-data register number |
| out_size_reg | output | 5 | Byte-count register number |
| out_dest_reg | output | 5 | Destination register number |
| out_nontemp | output | 1 | Non-temporal flag |
| out_unpriv | output | 1 | Unprivileged-access flag |
| out_undef | output | 1 | Recognised word with an illegal register combination |
| out_syndrome | output | 25 | Exception syndrome word |

## Verification
Random words are forced onto the opcode pattern with register numbers drawn from a narrow range near 31. This makes collisions between operands, and the number 31 in each operand slot, occur often. A decoder that checks only some of the operand pairs, or that also treats a data register of 31 as illegal, reports the wrong undefined status on these words.

Words with phase 11, and words with a single opcode bit flipped, are driven as near misses. A decoder with a loose match raises valid on them, or raises undefined on them.

Idle and non-matching cycles are interleaved with recognised words. An output stage that follows every input, rather than holding its last value, changes the held fields in those cycles. Each syndrome field is compared on its own, so a register number in the wrong slot, or a wrong epilogue bit, shows up as a mismatch.

// File: rtl/mset_pkg.sv
package mset_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int SYN_W  = 25;

  // syndrome field positions (consumed by the exception stage)
  localparam int SYN_RD_LSB   = 10;
  localparam int SYN_RS_LSB   = 5;
  localparam int SYN_RN_LSB   = 0;
  localparam int SYN_WRONG    = 17;
  localparam int SYN_EPI      = 18;
  localparam int SYN_OPT_LSB  = 19;
  localparam int SYN_FMT      = 24;

  typedef enum logic [1:0] {
    PH_PROLOGUE = 2'b00,
    PH_MAIN     = 2'b01,
    PH_EPILOGUE = 2'b10,
    PH_NONE     = 2'b11
  } mset_phase_e;

  typedef struct packed {
    mset_phase_e        phase;
    logic [REG_W-1:0]   rs;
    logic [REG_W-1:0]   rn;
    logic [REG_W-1:0]   rd;
    logic               nontemp;
    logic               unpriv;
  } mset_fields_t;

  function automatic logic [SYN_W-1:0] build_syndrome(input mset_fields_t f);
    logic [SYN_W-1:0] s;
    s = '0;
    s[SYN_RD_LSB +: REG_W] = f.rd;
    s[SYN_RS_LSB +: REG_W] = f.rs;
    s[SYN_RN_LSB +: REG_W] = f.rn;
    s[SYN_OPT_LSB +: 2]    = {f.nontemp, f.unpriv};
    s[SYN_EPI]             = (f.phase == PH_EPILOGUE);
    s[SYN_WRONG]           = 1'b0;
    s[SYN_FMT]             = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/mset_field_decode.sv
module mset_field_decode
  import mset_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output logic              is_mset,
  output mset_fields_t      fields
);
  localparam logic [1:0] TOP_BITS = 2'b00;
  localparam logic [8:0] MID_BITS = 9'b011001110;
  localparam logic [1:0] LOW_BITS = 2'b01;

  logic fixed_ok;
  logic phase_ok;

  assign fixed_ok = (word[31:30] == TOP_BITS) &&
                    (word[29:21] == MID_BITS) &&
                    (word[11:10] == LOW_BITS);
  assign phase_ok = (word[15:14] != 2'b11);
  assign is_mset  = fixed_ok && phase_ok;

  always_comb begin
    fields.phase   = mset_phase_e'(word[15:14]);
    fields.rs      = word[20:16];
    fields.rn      = word[9:5];
    fields.rd      = word[4:0];
    fields.nontemp = word[13];
    fields.unpriv  = word[12];
  end
endmodule

// File: rtl/mset_reg_check.sv
module mset_reg_check
  import mset_pkg::*;
(
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] rn,
  input  logic [REG_W-1:0] rd,
  output logic             overlap,
  output logic             top_reg,
  output logic             illegal
);
  localparam int NOPS = 3;
  localparam logic [REG_W-1:0] TOP_IDX = '1;

  logic [REG_W-1:0] ops [NOPS];
  logic [NOPS-1:0]  pair_hit;

  assign ops[0] = rs;
  assign ops[1] = rn;
  assign ops[2] = rd;

  for (genvar i = 0; i < NOPS; i++) begin : g_pair
    assign pair_hit[i] = (ops[i] == ops[(i + 1) % NOPS]);
  end

  assign overlap = |pair_hit;
  assign top_reg = (rd == TOP_IDX) || (rn == TOP_IDX);
  assign illegal = overlap || top_reg;
endmodule

// File: rtl/mset_syndrome_build.sv
module mset_syndrome_build
  import mset_pkg::*;
(
  input  mset_fields_t     fields,
  output logic [SYN_W-1:0] syndrome
);
  assign syndrome = build_syndrome(fields);
endmodule

// File: rtl/memset_decoder.sv
module memset_decoder
  import mset_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  output logic [1:0]        out_phase,
  output logic [4:0]        out_data_reg,
  output logic [4:0]        out_size_reg,
  output logic [4:0]        out_dest_reg,
  output logic              out_nontemp,
  output logic              out_unpriv,
  output logic              out_undef,
  output logic [24:0]       out_syndrome
);
  logic             is_mset;
  mset_fields_t     fields;
  logic             overlap;
  logic             top_reg;
  logic             illegal;
  logic [SYN_W-1:0] syn_next;
  logic             hit;

  mset_field_decode u_decode (
    .word    (in_word),
    .is_mset (is_mset),
    .fields  (fields)
  );

  mset_reg_check u_check (
    .rs      (fields.rs),
    .rn      (fields.rn),
    .rd      (fields.rd),
    .overlap (overlap),
    .top_reg (top_reg),
    .illegal (illegal)
  );

  mset_syndrome_build u_syn (
    .fields   (fields),
    .syndrome (syn_next)
  );

  assign hit = in_valid && is_mset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_undef    <= 1'b0;
      out_phase    <= 2'b00;
      out_data_reg <= '0;
      out_size_reg <= '0;
      out_dest_reg <= '0;
      out_nontemp  <= 1'b0;
      out_unpriv   <= 1'b0;
      out_syndrome <= '0;
    end else begin
      out_valid <= hit;
      out_undef <= hit && illegal;
      if (hit) begin
        out_phase    <= fields.phase;
        out_data_reg <= fields.rs;
        out_size_reg <= fields.rn;
        out_dest_reg <= fields.rd;
        out_nontemp  <= fields.nontemp;
        out_unpriv   <= fields.unpriv;
        out_syndrome <= syn_next;
      end
    end
  end

  AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> out_valid); // R1
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!out_valid && !out_undef)); // R2
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_phase != 2'b11)); // R3
  AST_OVERLAP_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_data_reg == out_size_reg || out_data_reg == out_dest_reg ||
                   out_size_reg == out_dest_reg)) |-> out_undef); // R6
  AST_TOP_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_dest_reg == 5'd31 || out_size_reg == 5'd31)) |-> out_undef); // R7
  AST_SYN_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_syndrome[14:10] == out_dest_reg &&
                   out_syndrome[9:5] == out_data_reg &&
                   out_syndrome[4:0] == out_size_reg)); // R8
  AST_SYN_EPI: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_syndrome[18] == (out_phase == 2'b10))); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(out_syndrome) && $stable(out_phase))); // R11
endmodule

// File: tb/memset_decoder_test.sv
module memset_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid, out_nontemp, out_unpriv, out_undef;
  logic [1:0]  out_phase;
  logic [4:0]  out_data_reg, out_size_reg, out_dest_reg;
  logic [24:0] out_syndrome;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // expected held state
  logic [1:0]  h_phase = '0;
  logic [4:0]  h_rs = '0, h_rn = '0, h_rd = '0;
  logic        h_nt = 0, h_up = 0;
  logic [24:0] h_syn = '0;

  always #2.5 clk = ~clk;

  memset_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_phase(out_phase), .out_data_reg(out_data_reg),
    .out_size_reg(out_size_reg), .out_dest_reg(out_dest_reg),
    .out_nontemp(out_nontemp), .out_unpriv(out_unpriv),
    .out_undef(out_undef), .out_syndrome(out_syndrome)
  );

  function automatic bit ref_match(input logic [31:0] w);
    return w[31:21] == 11'b00011001110 && w[11:10] == 2'b01 && w[15:14] != 2'b11;
  endfunction

  function automatic bit ref_undef(input logic [31:0] w);
    logic [4:0] d, s, n;
    d = w[20:16]; n = w[9:5]; s = w[4:0];
    return (d == n) || (d == s) || (n == s) || (s == 5'd31) || (n == 5'd31);
  endfunction

  function automatic logic [24:0] ref_syn(input logic [31:0] w);
    logic [24:0] r;
    r = {1'b1, 3'b000, w[13], w[12], (w[15:14] == 2'b10), 1'b0, 2'b00,
         w[4:0], w[20:16], w[9:5]};
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input bit v, input logic [31:0] w);
    bit h;
    in_valid = v;
    in_word = w;
    @(posedge clk);
    @(negedge clk);
    h = v && ref_match(w);
    if (h) begin
      h_phase = w[15:14]; h_rs = w[20:16]; h_rn = w[9:5]; h_rd = w[4:0];
      h_nt = w[13]; h_up = w[12]; h_syn = ref_syn(w);
    end
    chk(h ? "R1" : "R2", "valid", {31'd0, out_valid}, {31'd0, h});
    chk(h ? "R6/R7" : "R2", "undef", {31'd0, out_undef}, {31'd0, h && ref_undef(w)});
    chk(h ? "R3" : "R11", "phase", {30'd0, out_phase}, {30'd0, h_phase});
    chk(h ? "R4" : "R11", "regs", {17'd0, out_data_reg, out_size_reg, out_dest_reg},
        {17'd0, h_rs, h_rn, h_rd});
    chk(h ? "R5" : "R11", "flags", {30'd0, out_nontemp, out_unpriv}, {30'd0, h_nt, h_up});
    chk(h ? "R8" : "R11", "syn_regs", {17'd0, out_syndrome[14:0]}, {17'd0, h_syn[14:0]});
    chk(h ? "R9" : "R11", "syn_upper", {22'd0, out_syndrome[24:15]}, {22'd0, h_syn[24:15]});
  endtask

  function automatic logic [31:0] mk(input logic [1:0] ph, input logic nt, input logic up,
                                     input logic [4:0] rs, input logic [4:0] rn,
                                     input logic [4:0] rd);
    return {2'b00, 9'b011001110, rs, ph, nt, up, 2'b01, rn, rd};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "rst_valid", {31'd0, out_valid}, 32'd0);
    chk("R10", "rst_undef", {31'd0, out_undef}, 32'd0);
    chk("R10", "rst_syn", {7'd0, out_syndrome}, 32'd0);
    chk("R10", "rst_regs", {17'd0, out_data_reg, out_size_reg, out_dest_reg}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    apply(1, mk(2'b00, 0, 0, 5'd1, 5'd2, 5'd3));   // R1 legal prologue
    apply(1, mk(2'b01, 1, 0, 5'd4, 5'd5, 5'd6));   // R3 main
    apply(1, mk(2'b10, 0, 1, 5'd7, 5'd8, 5'd9));   // R9 epilogue bit
    apply(1, mk(2'b11, 1, 1, 5'd1, 5'd2, 5'd3));   // R1 phase 11 rejected
    apply(1, mk(2'b00, 0, 0, 5'd31, 5'd2, 5'd3));  // R7 data 31 legal
    apply(1, mk(2'b00, 0, 0, 5'd1, 5'd2, 5'd31));  // R7 dest 31
    apply(1, mk(2'b01, 0, 0, 5'd1, 5'd31, 5'd3));  // R7 size 31
    apply(1, mk(2'b01, 0, 0, 5'd5, 5'd5, 5'd3));   // R6 data==size
    apply(1, mk(2'b10, 0, 0, 5'd5, 5'd2, 5'd5));   // R6 data==dest
    apply(1, mk(2'b10, 1, 1, 5'd1, 5'd6, 5'd6));   // R6 size==dest
    apply(0, mk(2'b00, 0, 0, 5'd10, 5'd11, 5'd12)); // R11 idle hold
    apply(1, mk(2'b00, 0, 0, 5'd1, 5'd2, 5'd3) ^ 32'h0000_0800); // R2 bit11 flip
    apply(1, mk(2'b00, 0, 0, 5'd1, 5'd2, 5'd3) | 32'h8000_0000); // R2 bit31
    // random
    for (int i = 0; i < 3000; i++) begin
      w = $urandom;
      if ($urandom % 4 != 0) begin
        w[31:21] = 11'b00011001110;
        w[11:10] = 2'b01;
        if ($urandom % 2 == 0) begin
          w[20:16] = 5'd28 + 5'($urandom % 4);
          w[9:5]   = 5'd28 + 5'($urandom % 4);
          w[4:0]   = 5'd28 + 5'($urandom % 4);
        end
        if ($urandom % 8 == 0) w = w ^ (32'd1 << ($urandom % 32));
      end
      apply(($urandom % 5) != 0, w);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule